// File: doc/BRIEF.md
# Timeslotted Card Response Transmitter

This block drives the load-modulation response a contactless card sends back to a reader. A receiver upstream reports the tick at which the reader's last frame ended. Given that timestamp, a response word, its bit count and a mode select, the block waits a fixed number of 212 kHz ticks. It then emits the response one bit per fixed-length slot by switching a subcarrier-enable output. Every slot boundary is derived from the shared absolute timestamp, never from the moment the block was started. This keeps the card's replies locked to the reader's frame grid whatever the latency of the logic in front of it.

Data bits are scrambled with a keystream bit from an external generator. The block pulses an advance strobe so that the generator steps through the silent wait as well as once per transmitted bit. The acknowledge mode is a separate case. It sends one unscrambled 1 after a much longer wait, and it still steps the keystream. When the last slot closes, the subcarrier is switched off and a one-clock done pulse follows. The end-of-last-slot timestamp is presented so the receiver can carry on timing from it.

Top module: `card_resp_tx`

## Requirements
- R1: While reset is held and in the first cycle after it, `sc_on`, `done`, `busy` and `ks_adv` are all 0.
- R2: In normal mode (`ack_mode`=0) the first bit slot begins when `now_ts` reaches `ref_ts`+70. The subcarrier stays off for every tick before that.
- R3: In acknowledge mode (`ack_mode`=1) exactly one slot is sent, beginning at `ref_ts`+758, with the subcarrier on for its whole length. The value is not XORed with `ks_bit`, and `tx_word`/`tx_len` are ignored.
- R4: Each slot lasts 21 ticks. Bit k of `tx_word` (k=0 first, least significant first) is sent in slot k, for `tx_len` slots.
- R5: The value sent in a data slot is `tx_word[k]` XOR the `ks_bit` present when the slot opens. A value of 1 means `sc_on`=1 and 0 means `sc_on`=0.
- R6: `ks_adv` pulses 2 times before the first slot of a normal frame and 35 times before an acknowledge. It pulses once more as each slot opens, so a run totals 2+`tx_len` or 36 pulses.
- R7: `sc_on` is 0 from the end of the last slot onward and whenever `busy` is 0.
- R8: `done` is high for exactly one clock, the clock after `sc_on` has gone to 0 at the end of the run. At that time `end_ts` equals `ref_ts` + wait + 21 × slots.
- R9: A `start` pulse while `busy` is 1 has no effect on the running transmission, its timing, its keystream use or `end_ts`.
- R10: All timestamp sums and comparisons are modulo 2^TS_W, so a run that crosses the wrap of `now_ts` keeps the same slot timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-clock request to begin a response; taken only when idle |
| ack_mode | input | 1 | 0 = scrambled data frame, 1 = acknowledge |
| tx_word | input | WORD_W | Response bits, least significant sent first |
| tx_len | input | LEN_W | Number of data bits (1..WORD_W) |
| ref_ts | input | TS_W | Tick at which the reader frame ended |
| now_ts | input | TS_W | Free-running 212 kHz tick count |
| ks_bit | input | 1 | Current keystream bit |
| ks_adv | output | 1 | Keystream advance strobe, one step per clock high |
| sc_on | output | 1 | Subcarrier enable |
| done | output | 1 | One-clock end-of-response pulse |
| busy | output | 1 | High while a response is in progress |
| end_ts | output | TS_W | Tick at which the last slot closes |

## Verification
The assertions assume that `now_ts` moves forward by at most one tick per clock, at fewer than one tick per several clocks. They also assume that `ref_ts` lies no more than half the counter range behind `now_ts`, and that a normal-mode `tx_len` is between 1 and WORD_W. The bench derives `now_ts` from a divide-by-four tick counter that starts just short of the 32-bit wrap. It places `ref_ts` only a few ticks behind the present tick and takes lengths from a vector table that stays in range. The keystream is a small LFSR model stepped on every `ks_adv`, with an override that pins the bit to 1 so that the XOR path and the unscrambled acknowledge can be told apart.

// File: rtl/crt_pkg.sv
// Package: shared types for the timeslotted card response transmitter.
// Assumes nothing beyond being compiled before the modules that import it.
package crt_pkg;

    // Sequencer phases of one response run.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,  // waiting for a start request
        ST_PREP = 2'd1,  // silent wait, keystream pre-advance
        ST_BIT  = 2'd2,  // a slot is on air
        ST_FIN  = 2'd3   // subcarrier just dropped, done follows
    } crt_state_e;

endpackage

// File: rtl/crt_deadline.sv
// Module: crt_deadline
// Holds the absolute tick at which the current wait or slot ends and flags
// when the running tick count has reached it. Comparison is a wrap-safe
// signed difference, so it assumes the deadline never lies more than half
// the counter range away from now_ts.
module crt_deadline #(
    parameter int TS_W = 32,
    parameter int STEP = 21
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [TS_W-1:0] load_val,
    input  logic            step,
    input  logic [TS_W-1:0] now_ts,
    output logic [TS_W-1:0] target,
    output logic            hit
);

    logic [TS_W-1:0] gap;

    // Distance from the deadline to the present tick, modulo 2^TS_W.
    always_comb begin
        gap = now_ts - target;
        hit = ~gap[TS_W-1];
    end

    // Deadline register: absolute load, or push forward by one slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target <= '0;
        end else if (load) begin
            target <= load_val;
        end else if (step) begin
            target <= target + TS_W'(STEP);
        end
    end

    // A slot may only be opened once its start tick has arrived.
    assert_step_on_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> hit);

endmodule

// File: rtl/crt_shifter.sv
// Module: crt_shifter
// Holds the response word and the number of slots still to send. Presents
// the next bit to send and shifts towards the least significant end.
// Assumes load and shift are never requested in the same cycle.
module crt_shifter #(
    parameter int WORD_W = 16,
    parameter int LEN_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    input  logic [LEN_W-1:0]  len_in,
    input  logic              shift,
    output logic              cur_bit,
    output logic              empty
);

    logic [WORD_W-1:0] word_q;
    logic [LEN_W-1:0]  left_q;

    // Word and slot counter: capture on load, consume one bit per shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            left_q <= '0;
        end else if (load) begin
            word_q <= word_in;
            left_q <= len_in;
        end else if (shift) begin
            word_q <= word_q >> 1;
            left_q <= left_q - LEN_W'(1);
        end
    end

    // Next outgoing bit and exhaustion flag.
    always_comb begin
        cur_bit = word_q[0];
        empty   = (left_q == '0);
    end

    assert_no_shift_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        shift |-> !empty);

endmodule

// File: rtl/card_resp_tx.sv
// Module: card_resp_tx (top)
// Sends a card-to-reader response in fixed tick slots timed from an
// absolute reference timestamp. A normal frame is scrambled with an external
// keystream; an acknowledge is one plain 1 after a long wait. Assumes now_ts
// advances by at most one per clock, ref_ts is recent, and 1 <= tx_len <= WORD_W
// in normal mode.
module card_resp_tx
    import crt_pkg::*;
#(
    parameter int TS_W       = 32,
    parameter int WORD_W     = 16,
    parameter int LEN_W      = $clog2(WORD_W + 1),
    parameter int FRAME_WAIT = 70,
    parameter int ACK_WAIT   = 758,
    parameter int BIT_TICKS  = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ack_mode,
    input  logic [WORD_W-1:0] tx_word,
    input  logic [LEN_W-1:0]  tx_len,
    input  logic [TS_W-1:0]   ref_ts,
    input  logic [TS_W-1:0]   now_ts,
    input  logic              ks_bit,
    output logic              ks_adv,
    output logic              sc_on,
    output logic              done,
    output logic              busy,
    output logic [TS_W-1:0]   end_ts
);

    localparam int FRAME_ADV = FRAME_WAIT / BIT_TICKS - 1;
    localparam int ACK_ADV   = ACK_WAIT / BIT_TICKS - 1;
    localparam int ADV_MAX   = (ACK_ADV > FRAME_ADV) ? ACK_ADV : FRAME_ADV;
    localparam int ADV_W     = $clog2(ADV_MAX + 1);

    crt_state_e        state_q;
    logic              ack_q;
    logic [ADV_W-1:0]  adv_left_q;
    logic              sc_q;
    logic              done_q;

    logic              accept;
    logic              adv_pending;
    logic              slot_hit;
    logic              emit_point;
    logic              send;
    logic              finish;
    logic              tx_value;
    logic              cur_bit;
    logic              sh_empty;
    logic [TS_W-1:0]   first_deadline;
    logic [LEN_W-1:0]  load_len;

    // Slot clock: absolute deadline of the current wait or slot.
    crt_deadline #(
        .TS_W (TS_W),
        .STEP (BIT_TICKS)
    ) u_deadline (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (first_deadline),
        .step     (send),
        .now_ts   (now_ts),
        .target   (end_ts),
        .hit      (slot_hit)
    );

    // Bit source: response word and remaining slot count.
    crt_shifter #(
        .WORD_W (WORD_W),
        .LEN_W  (LEN_W)
    ) u_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .word_in (tx_word),
        .len_in  (load_len),
        .shift   (send),
        .cur_bit (cur_bit),
        .empty   (sh_empty)
    );

    // Decode of run events for the current cycle.
    always_comb begin
        accept         = start && (state_q == ST_IDLE);
        first_deadline = ref_ts + (ack_mode ? TS_W'(ACK_WAIT) : TS_W'(FRAME_WAIT));
        load_len       = ack_mode ? LEN_W'(1) : tx_len;
        adv_pending    = (state_q == ST_PREP) && (adv_left_q != '0);
        emit_point     = slot_hit &&
                         (((state_q == ST_PREP) && (adv_left_q == '0)) ||
                          (state_q == ST_BIT));
        send           = emit_point && !sh_empty;
        finish         = emit_point && sh_empty;
        tx_value       = ack_q ? 1'b1 : (cur_bit ^ ks_bit);
        ks_adv         = adv_pending || send;
        busy           = (state_q != ST_IDLE);
        sc_on          = sc_q;
        done           = done_q;
    end

    // Run sequencer: idle, pre-advance wait, slots, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            ack_q      <= 1'b0;
            adv_left_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q    <= ST_PREP;
                        ack_q      <= ack_mode;
                        adv_left_q <= ack_mode ? ADV_W'(ACK_ADV) : ADV_W'(FRAME_ADV);
                    end
                end
                ST_PREP: begin
                    if (adv_pending) begin
                        adv_left_q <= adv_left_q - ADV_W'(1);
                    end else if (send) begin
                        state_q <= ST_BIT;
                    end else if (finish) begin
                        state_q <= ST_FIN;
                    end
                end
                ST_BIT: begin
                    if (finish) begin
                        state_q <= ST_FIN;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Subcarrier enable: set at each slot opening, cleared at run end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_q <= 1'b0;
        end else if (send) begin
            sc_q <= tx_value;
        end else if (finish) begin
            sc_q <= 1'b0;
        end
    end

    // Done pulse: one clock after the subcarrier has been released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= (state_q == ST_FIN);
        end
    end

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sc_on);

    assert_no_adv_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ks_adv);

    assert_done_after_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!sc_on && !$past(sc_on)));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_sc_moves_on_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_on != $past(sc_on)) |-> $past(slot_hit));

    assert_ack_plain_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_BIT) && ack_q) |-> sc_on);

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && !slot_hit) |=> $stable(end_ts));

    assert_len_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !ack_mode) |-> (tx_len != '0 && tx_len <= LEN_W'(WORD_W)));

endmodule

// File: tb/card_resp_tx_bench.sv
// Bench for card_resp_tx: vector table walked by one loop, then directed
// checks for reset, an ignored start and the acknowledge corner.
module card_resp_tx_bench;

    localparam int TS_W = 32;
    localparam int WORD_W = 16;
    localparam int LEN_W = 5;
    localparam int TICK_DIV = 4;
    localparam logic [6:0] KS_SEED = 7'h5B;

    typedef struct packed {
        logic [15:0] word;
        logic [4:0]  len;
        logic        ack;
        logic [7:0]  off;
        logic        pin1;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{word: 16'hA5C3, len: 5'd16, ack: 1'b0, off: 8'd0,  pin1: 1'b0},
        '{word: 16'h0001, len: 5'd1,  ack: 1'b0, off: 8'd5,  pin1: 1'b0},
        '{word: 16'h7E81, len: 5'd11, ack: 1'b0, off: 8'd30, pin1: 1'b0},
        '{word: 16'h0000, len: 5'd12, ack: 1'b0, off: 8'd3,  pin1: 1'b1},
        '{word: 16'h0000, len: 5'd0,  ack: 1'b1, off: 8'd10, pin1: 1'b1},
        '{word: 16'hFFFF, len: 5'd7,  ack: 1'b1, off: 8'd0,  pin1: 1'b0}
    };

    logic              clk;
    logic              rst_n;
    logic              start;
    logic              ack_mode;
    logic [WORD_W-1:0] tx_word;
    logic [LEN_W-1:0]  tx_len;
    logic [TS_W-1:0]   ref_ts;
    logic [TS_W-1:0]   now_ts;
    logic              ks_bit;
    logic              ks_adv;
    logic              sc_on;
    logic              done;
    logic              busy;
    logic [TS_W-1:0]   end_ts;

    int          total;
    int          bad;
    logic [1:0]  div;
    logic [6:0]  lfsr;
    int          adv_total;
    logic        pin_ks;
    logic        log_en;
    logic        log_clr;
    logic [TS_W-1:0] log_ref;
    logic [TS_W-1:0] log_idx;
    logic        hist [0:1023];

    card_resp_tx #(
        .TS_W   (TS_W),
        .WORD_W (WORD_W),
        .LEN_W  (LEN_W)
    ) u_card_resp_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .ack_mode (ack_mode),
        .tx_word  (tx_word),
        .tx_len   (tx_len),
        .ref_ts   (ref_ts),
        .now_ts   (now_ts),
        .ks_bit   (ks_bit),
        .ks_adv   (ks_adv),
        .sc_on    (sc_on),
        .done     (done),
        .busy     (busy),
        .end_ts   (end_ts)
    );

    // 125 MHz clock.
    initial clk = 1'b0;
    always #4 clk = ~clk;

    // Tick source: one tick every TICK_DIV clocks, starting just short of wrap.
    always @(posedge clk) begin
        if (!rst_n) begin
            div    <= '0;
            now_ts <= 32'hFFFF_FF40;
        end else begin
            div <= div + 2'd1;
            if (div == 2'(TICK_DIV - 1)) now_ts <= now_ts + 32'd1;
        end
    end

    // Keystream model: small LFSR stepped on every advance strobe.
    always @(posedge clk) begin
        if (!rst_n) begin
            lfsr      <= KS_SEED;
            adv_total <= 0;
        end else if (ks_adv) begin
            lfsr      <= {lfsr[5:0], lfsr[6] ^ lfsr[5]};
            adv_total <= adv_total + 1;
        end
    end
    assign ks_bit = pin_ks ? 1'b1 : lfsr[0];

    // Per-tick subcarrier log, sampled on the last clock of each tick.
    always @(negedge clk) begin
        if (log_clr) begin
            for (int i = 0; i < 1024; i++) hist[i] = 1'b0;
        end else if (log_en && div == 2'(TICK_DIV - 1)) begin
            log_idx = now_ts - log_ref;
            if (log_idx < 32'd1024) hist[log_idx[9:0]] = sc_on;
        end
    end

    function automatic logic ks_at(input int n);
        logic [6:0] s;
        s = KS_SEED;
        for (int i = 0; i < n; i++) s = {s[5:0], s[6] ^ s[5]};
        return s[0];
    endfunction

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input logic intrude);
        int          wait_t;
        int          slots;
        int          adv0;
        int          cyc;
        int          e_pre;
        int          e_slot;
        int          e_post;
        logic [TS_W-1:0] rts;
        logic [TS_W-1:0] exp_end;
        logic        exp_bit;
        string       slot_tag;
        @(negedge clk);
        wait_t  = v.ack ? 758 : 70;
        slots   = v.ack ? 1 : int'(v.len);
        pin_ks  = v.pin1;
        rts     = now_ts - TS_W'(v.off);
        exp_end = rts + TS_W'(wait_t + 21 * slots);
        log_clr = 1'b1;
        @(negedge clk);
        log_clr = 1'b0;
        log_ref = rts;
        log_en  = 1'b1;
        adv0    = adv_total;
        start    = 1'b1;
        ack_mode = v.ack;
        tx_word  = v.word;
        tx_len   = v.len;
        ref_ts   = rts;
        @(negedge clk);
        start   = 1'b0;
        tx_word = ~v.word;
        tx_len  = 5'd3;
        ref_ts  = '0;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (intrude && cyc == 100) begin
                start    = 1'b1;
                ack_mode = ~v.ack;
                tx_word  = 16'hFFFF;
                ref_ts   = now_ts;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        chk(done == 1'b1, "R8 done pulse seen", done, 1);
        chk(sc_on == 1'b0, "R8 carrier off at done", sc_on, 0);
        chk(end_ts == exp_end, "R8 end timestamp", end_ts, exp_end);
        chk(adv_total - adv0 == (v.ack ? 35 : 2) + slots, "R6 advance count",
            adv_total - adv0, (v.ack ? 35 : 2) + slots);
        @(negedge clk);
        chk(done == 1'b0, "R8 done one clock", done, 0);
        repeat (30 * TICK_DIV) @(negedge clk);
        log_en = 1'b0;
        e_pre = 0; e_slot = 0; e_post = 0;
        for (int t = 0; t < wait_t + 21 * slots + 29; t++) begin
            if (t < wait_t) begin
                if (hist[t] != 1'b0) e_pre++;
            end else if (t < wait_t + 21 * slots) begin
                if (v.ack) exp_bit = 1'b1;
                else exp_bit = v.word[(t - wait_t) / 21] ^
                               (v.pin1 ? 1'b1 : ks_at(adv0 + 2 + (t - wait_t) / 21));
                if (hist[t] != exp_bit) e_slot++;
            end else begin
                if (hist[t] != 1'b0) e_post++;
            end
        end
        slot_tag = v.ack ? "R3 acknowledge slot" : (v.pin1 ? "R5 keystream xor" : "R4 slot contents");
        chk(e_pre == 0, v.ack ? "R3 silent before ack" : "R2 silent before first slot", e_pre, 0);
        chk(e_slot == 0, slot_tag, e_slot, 0);
        chk(e_post == 0, "R7 carrier off after run", e_post, 0);
        if (exp_end < rts) chk(e_pre + e_slot + e_post == 0, "R10 wrap crossing", e_pre + e_slot + e_post, 0);
        if (intrude) chk(e_slot == 0 && end_ts == exp_end, "R9 start ignored while busy", end_ts, exp_end);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Main sequence.
    initial begin
        total = 0; bad = 0;
        rst_n = 1'b0; start = 1'b0; ack_mode = 1'b0;
        tx_word = '0; tx_len = '0; ref_ts = '0;
        pin_ks = 1'b0; log_en = 1'b0; log_clr = 1'b0; log_ref = '0;
        repeat (5) @(negedge clk);
        chk(sc_on == 1'b0, "R1 carrier in reset", sc_on, 0);
        chk(done == 1'b0, "R1 done in reset", done, 0);
        chk(busy == 1'b0, "R1 busy in reset", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ks_adv == 1'b0 && busy == 1'b0, "R1 quiet after reset", {ks_adv, busy}, 0);
        for (int k = 0; k < NVEC; k++) run_vec(VECS[k], 1'b0);
        // Directed: a second start during a normal frame.
        run_vec('{word: 16'h3C5A, len: 5'd9, ack: 1'b0, off: 8'd2, pin1: 1'b0}, 1'b1);
        // Directed: shortest frame with zero bit and pinned keystream.
        run_vec('{word: 16'h0000, len: 5'd1, ack: 1'b0, off: 8'd69, pin1: 1'b1}, 1'b0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule